// File: doc/BRIEF.md
# I2C Register Read-Pointer Slave

This block is an I2C target that serves a bank of byte-wide registers through a stored register pointer. The pointer survives from one bus transaction to the next. A master loads it with a short write: the device address with the direction bit clear, then one register-address byte. A later read with no address phase returns bytes starting from the stored pointer. A master can also do a combined access: it writes the register address, issues a repeated START and reads back from that register at once.

The register contents are not held here. The block presents the pointer on a parallel address output and takes the matching byte back on a parallel data input within the same cycle. Both bus lines are sampled into the system clock domain. The block only ever pulls SDA low or releases it. It has no clock stretching, 10-bit addressing, general call or arbitration.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and the pointer on `rd_addr_o` is 0.
- R2: SCL and SDA pass through a two-stage synchroniser. A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A START that arrives while a transfer is open restarts address decoding.
- R3: The first byte after a START is the control byte, sent MSB first. Its upper seven bits are the device address and bit 0 is the direction (1 = read, 0 = write). When the address equals `DEV_ADDR`, the block pulls SDA low during the ninth clock.
- R4: A control byte whose address differs gets no acknowledge. All following bus activity is ignored, and the pointer left unchanged, until the next START or STOP.
- R5: In a write, the byte after the control byte is a register address. It is acknowledged and loaded into the pointer. A STOP that follows an address write with no read leaves the pointer at that value.
- R6: Any write byte after the register-address byte gets no acknowledge and does not change the pointer.
- R7: In a read, the block returns the byte at the pointer, MSB first. `rd_addr_o` always shows the pointer.
- R8: When the master acknowledges a read byte, the pointer advances by one and the next byte follows. When the master does not acknowledge, the block releases SDA and drives nothing more in that transfer.
- R9: A STOP that ends a transfer in which at least one byte was read advances the pointer by one. A read that ends at register n is therefore followed by a read that starts at n + 1.
- R10: In a combined access, a repeated START after the acknowledged register-address byte ends the write without advancing the pointer. The read that follows starts at the register just written.
- R11: The pointer saturates at its maximum value (all ones). A burst that reaches it returns the last register again, and no acknowledge or STOP wraps it to zero.
- R12: The block drives SDA open-drain: `sda_oe_o` = 1 pulls the line low. It changes `sda_oe_o` only after an SCL falling edge or a START or STOP, so SDA holds steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr_o | output | ADDR_W | Current register pointer, used as the read address |
| rd_data_i | input | 8 | Register byte at `rd_addr_o`, valid in the same cycle |

## Verification
A pointer that has drifted shows up on `rd_addr_o` within a few cycles of the STOP or the acknowledge that moved it. A pointer that advances at the wrong moment returns the wrong byte on the very next read bit. A wrong protocol phase shows up within one SCL period: an acknowledge is missing or extra, or data bits are driven during a phase where SDA must be released. The bench therefore compares `sda_oe_o` against its model in every SCL high phase. It also checks the pointer after every STOP.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_CTRL_ACK,
        PH_REG,
        PH_REG_ACK,
        PH_TX,
        PH_MACK,
        PH_SKIP
    } phase_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_ptr_sync.sv
module i2c_ptr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    // Index STAGES-1 is the synchronised level; index STAGES is the previous one.
    localparam int unsigned PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl;
        logic [PIPE_W-1:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    logic scl_now, scl_prev, sda_now, sda_prev;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[PIPE_W-2:0], scl_i};
        s_d.sda = {s_q.sda[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_now  = s_q.scl[STAGES-1];
    assign scl_prev = s_q.scl[STAGES];
    assign sda_now  = s_q.sda[STAGES-1];
    assign sda_prev = s_q.sda[STAGES];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_ptr_ctrl.sv
module i2c_ptr_ctrl
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h3A,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              sda_oe_o
);

    localparam logic [ADDR_W-1:0] PTR_MAX  = '1;
    localparam logic [3:0]        BIT_LAST = 4'(BYTE_W);

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          cnt;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic                oe;
        logic                used;   // a byte was read since the last STOP
        logic                mack;   // master acknowledged the last byte
        logic [ADDR_W-1:0]   ptr;
    } ctrl_t;

    ctrl_t c_d, c_q;

    function automatic logic [ADDR_W-1:0] sat_inc(input logic [ADDR_W-1:0] p);
        return (p == PTR_MAX) ? p : p + 1'b1;
    endfunction

    always_comb begin
        c_d = c_q;
        if (stop_i) begin
            c_d.phase = PH_IDLE;
            c_d.oe    = 1'b0;
            c_d.used  = 1'b0;
            if (c_q.used) begin
                c_d.ptr = sat_inc(c_q.ptr);
            end
        end else if (start_i) begin
            c_d.phase = PH_CTRL;
            c_d.cnt   = '0;
            c_d.oe    = 1'b0;
        end else begin
            unique case (c_q.phase)
                PH_CTRL: begin
                    if (scl_rise_i) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_i};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall_i && c_q.cnt == BIT_LAST) begin
                        if (c_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                            c_d.rw    = c_q.sh[0];
                            c_d.oe    = 1'b1;
                            c_d.phase = PH_CTRL_ACK;
                        end else begin
                            c_d.phase = PH_SKIP;
                        end
                    end
                end
                PH_CTRL_ACK: begin
                    if (scl_fall_i) begin
                        c_d.cnt = '0;
                        if (c_q.rw) begin
                            c_d.sh    = rd_data_i;
                            c_d.oe    = ~rd_data_i[BYTE_W-1];
                            c_d.used  = 1'b1;
                            c_d.phase = PH_TX;
                        end else begin
                            c_d.oe    = 1'b0;
                            c_d.phase = PH_REG;
                        end
                    end
                end
                PH_REG: begin
                    if (scl_rise_i) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_i};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall_i && c_q.cnt == BIT_LAST) begin
                        c_d.ptr   = c_q.sh[ADDR_W-1:0];
                        c_d.used  = 1'b0;
                        c_d.oe    = 1'b1;
                        c_d.phase = PH_REG_ACK;
                    end
                end
                PH_REG_ACK: begin
                    if (scl_fall_i) begin
                        c_d.oe    = 1'b0;
                        c_d.phase = PH_SKIP;
                    end
                end
                PH_TX: begin
                    if (scl_rise_i) begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (c_q.cnt == BIT_LAST) begin
                            c_d.oe    = 1'b0;
                            c_d.phase = PH_MACK;
                        end else begin
                            c_d.sh = {c_q.sh[BYTE_W-2:0], 1'b0};
                            c_d.oe = ~c_q.sh[BYTE_W-2];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise_i) begin
                        c_d.mack = ~sda_i;
                        if (!sda_i) begin
                            c_d.ptr = sat_inc(c_q.ptr);
                        end
                    end else if (scl_fall_i) begin
                        if (c_q.mack) begin
                            c_d.cnt   = '0;
                            c_d.sh    = rd_data_i;
                            c_d.oe    = ~rd_data_i[BYTE_W-1];
                            c_d.phase = PH_TX;
                        end else begin
                            c_d.phase = PH_SKIP;
                        end
                    end
                end
                default: begin
                    c_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_addr_o = c_q.ptr;
    assign sda_oe_o  = c_q.oe;

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h3A,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    logic sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;

    i2c_ptr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_w),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_ptr_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_w),
        .scl_rise_i (scl_rise_w),
        .scl_fall_i (scl_fall_w),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .rd_data_i  (rd_data_i),
        .rd_addr_o  (rd_addr_o),
        .sda_oe_o   (sda_oe_o)
    );

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              start,
    input logic              stop,
    input logic              sda_oe,
    input logic [ADDR_W-1:0] rd_addr
);

    localparam logic [ADDR_W-1:0] PTR_TOP = '1;

    // R12
    oe_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start || stop));

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !sda_oe);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe);

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_addr) && !$past(scl_fall)) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

    // R11
    ptr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_addr) == PTR_TOP && !$past(scl_fall)) |-> rd_addr == PTR_TOP);

    // R5
    ptr_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> $past(scl_rise || scl_fall || stop));

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start    (start_w),
    .stop     (stop_w),
    .sda_oe   (sda_oe_o),
    .rd_addr  (rd_addr_o)
);

// File: tb/test_i2c_ptr_slave.sv
`timescale 1ns/1ps
module test_i2c_ptr_slave;

    localparam logic [6:0] DEV = 7'h3A;
    localparam int AW = 8;
    localparam int PMAX = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data;
    wire  sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    // register bank contents: a fixed function of the address
    assign rd_data = {rd_addr[3:0], rd_addr[7:4]} ^ 8'h96;

    i2c_ptr_slave #(.DEV_ADDR(DEV), .ADDR_W(AW), .SYNC_STAGES(2)) i_i2c_ptr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe_o  (sda_oe),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    bit win_en = 1'b0;
    logic exp_oe = 1'b0;
    int hcnt = 0;

    // behavioural model of the pointer
    int mptr = 0;
    bit mused = 1'b0;

    function automatic logic [7:0] reg_of(int a);
        logic [7:0] b = 8'(a);
        return {b[3:0], b[7:4]} ^ 8'h96;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the open-drain enable during SCL high
    always @(negedge clk) begin
        if (scl_m) hcnt <= hcnt + 1; else hcnt <= 0;
        if (win_en && scl_m && hcnt >= 3 && hcnt <= 6) begin
            nchk++;
            if (sda_oe !== exp_oe) begin
                nfail++;
                $display("FAIL R12 sda_oe actual=%0b expected=%0b at %0t", sda_oe, exp_oe, $time);
            end
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        scl_m = 1'b0; hold(4);
        sda_m = b; exp_oe = 1'b0; hold(4);
        scl_m = 1'b1; hold(8);
    endtask

    task automatic bit_in(logic eoe, output logic got);
        scl_m = 1'b0; hold(4);
        sda_m = 1'b1; exp_oe = eoe; hold(4);
        scl_m = 1'b1; hold(4);
        got = sda_bus; hold(4);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; hold(4);
        sda_m = 1'b1; exp_oe = 1'b0; hold(4);
        scl_m = 1'b1; hold(4);
        sda_m = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; hold(4);
        sda_m = 1'b0; exp_oe = 1'b0; hold(4);
        scl_m = 1'b1; hold(4);
        sda_m = 1'b1; hold(8);
        if (mused) mptr = (mptr == PMAX) ? mptr : mptr + 1;
        mused = 1'b0;
    endtask

    task automatic wbyte(logic [7:0] b, bit exp_ack, string tag);
        logic got;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(exp_ack, got);
        chk(tag, int'(got), exp_ack ? 0 : 1);
    endtask

    task automatic rbyte(bit mack, string tag);
        logic [7:0] exp;
        logic [7:0] got;
        logic g;
        exp = reg_of(mptr);
        mused = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_in(~exp[i], g);
            got[i] = g;
        end
        bit_out(mack ? 1'b0 : 1'b1);
        chk(tag, int'(got), int'(exp));
        if (mack) mptr = (mptr == PMAX) ? mptr : mptr + 1;
    endtask

    task automatic set_ptr(int n, string tag);
        bus_start();
        wbyte({DEV, 1'b0}, 1'b1, "R3 write control ack");
        wbyte(8'(n), 1'b1, "R5 register address ack");
        mptr = n; mused = 1'b0;
        bus_stop();
        chk(tag, int'(rd_addr), mptr);
    endtask

    task automatic cur_read(int cnt, string tag);
        bus_start();
        wbyte({DEV, 1'b1}, 1'b1, "R3 read control ack");
        for (int k = 0; k < cnt; k++) rbyte(k != cnt - 1, tag);
        bus_stop();
        chk({tag, " pointer after stop (R9)"}, int'(rd_addr), mptr);
    endtask

    initial begin
        hold(5);
        // R1 reset state
        chk("R1 sda_oe at reset", int'(sda_oe), 0);
        chk("R1 pointer at reset", int'(rd_addr), 0);
        rst_n = 1'b1;
        hold(4);
        win_en = 1'b1;

        // R5: address write then STOP sets the pointer without advancing
        set_ptr(8'h10, "R5 pointer after address write");
        // R7, R8, R9: current-address burst of three
        cur_read(3, "R7 burst byte");
        // R9: next current read starts one past the last
        cur_read(1, "R9 single byte");

        // R10: combined access with repeated START
        bus_start();
        wbyte({DEV, 1'b0}, 1'b1, "R10 write control ack");
        wbyte(8'h40, 1'b1, "R10 register address ack");
        mptr = 8'h40; mused = 1'b0;
        bus_start();
        chk("R10 no advance on repeated start", int'(rd_addr), 8'h40);
        wbyte({DEV, 1'b1}, 1'b1, "R10 read control ack");
        rbyte(1'b1, "R10 first byte");
        rbyte(1'b0, "R10 second byte");
        bus_stop();
        chk("R10 pointer after stop", int'(rd_addr), mptr);

        // R4: foreign address, write then read, both ignored
        bus_start();
        wbyte({7'h15, 1'b0}, 1'b0, "R4 foreign write nack");
        wbyte(8'h77, 1'b0, "R4 ignored byte nack");
        bus_stop();
        chk("R4 pointer unchanged", int'(rd_addr), mptr);
        bus_start();
        wbyte({7'h3B, 1'b1}, 1'b0, "R4 foreign read nack");
        bus_stop();
        chk("R4 pointer unchanged after read", int'(rd_addr), mptr);
        cur_read(1, "R4 current read after foreign");

        // R6: extra write data is refused
        bus_start();
        wbyte({DEV, 1'b0}, 1'b1, "R6 control ack");
        wbyte(8'h20, 1'b1, "R6 register ack");
        mptr = 8'h20; mused = 1'b0;
        wbyte(8'h33, 1'b0, "R6 data byte nack");
        bus_stop();
        chk("R6 pointer holds register address", int'(rd_addr), 8'h20);

        // R2: START in mid-byte restarts decoding
        bus_start();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start();
        wbyte({DEV, 1'b1}, 1'b1, "R2 restart then read ack");
        rbyte(1'b0, "R2 byte after restart");
        bus_stop();
        chk("R2 pointer after stop", int'(rd_addr), mptr);

        // R11: saturation at the top register
        set_ptr(8'hFD, "R11 pointer near top");
        cur_read(4, "R11 burst to top");
        chk("R11 pointer held at top", int'(rd_addr), PMAX);
        cur_read(1, "R11 read at top");
        chk("R11 no wrap", int'(rd_addr), PMAX);

        win_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule